// File: doc/BRIEF.md
# Segmented Two-Level Paging Address Translator

This block turns a logical address, given as a segment selector and a 32-bit offset within that segment, into a physical address. It first checks the selector against the segment table length and fetches a two-word descriptor from the segment table. It then checks the offset against the descriptor's limit and adds the descriptor base to the offset to form a 32-bit linear address. That linear address is resolved through a directory table and a second-level table into a 20-bit frame number, and the frame number is joined with the 12-bit page offset.

All table contents come through a single word-wide read port. The port carries one read at a time, and each response is flagged by a valid strobe after any number of cycles. A request is accepted only while the block is idle. Each accepted request ends with a one-cycle completion pulse. That pulse carries either a physical address, a trap (selector out of range) or a segmentation fault (offset beyond limit). The table base registers are captured when a request is accepted.

Top module: `segpage_xlat`

## Requirements
- R1: When the selector is strictly greater than the table length input, the request completes with trap high and fault low. It completes one cycle after acceptance and issues no memory read.
- R2: A selector equal to the table length is in range and proceeds to the descriptor reads.
- R3: When the offset is strictly greater than the descriptor limit word, the request completes with fault high and trap low. No read is issued after the limit read. An offset equal to the limit proceeds.
- R4: The descriptor of selector s occupies word addresses tbl_base+2*s (limit) and tbl_base+2*s+1 (base).
- R5: The linear address is base plus offset modulo 2^32. The directory entry is read at dir_base + linear[31:22]. The second-level entry is read at word address {directory_entry[19:0], linear[21:12]}, zero-extended. Only bits 19:0 of an entry are used.
- R6: On success the physical address is {second_level_entry[19:0], linear[11:0]}, and trap and fault are low.
- R7: Reads are issued in the order limit, base, directory, second-level. Each read is a one-cycle pulse of mem_rd_o, and the next read is issued only after mem_rvalid_i has been seen for the previous one.
- R8: done_o is a one-cycle pulse per accepted request. trap_o and fault_o are high only together with done_o, never both at once, and phys_o is zero when either is high.
- R9: A request presented while a translation is in progress is ignored. It causes no read and no completion.
- R10: While reset is applied, done_o, trap_o, fault_o and mem_rd_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translation request (taken when idle) |
| seg_i | input | 13 | Segment selector |
| off_i | input | 32 | Offset within the segment |
| tbl_base_i | input | 32 | Segment table word address |
| tbl_len_i | input | 13 | Highest valid selector |
| dir_base_i | input | 32 | Directory table word address |
| mem_rd_o | output | 1 | Read strobe, one cycle |
| mem_addr_o | output | 32 | Read word address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Completion pulse |
| trap_o | output | 1 | Selector out of range (with done) |
| fault_o | output | 1 | Offset beyond limit (with done) |
| phys_o | output | 32 | Physical address (with done) |

## Verification
Translations are tried on selectors below, equal to and above the length register, and on offsets below, equal to and one above the limit. These cases separate the inclusive bound from an exclusive one and show which of trap or fault wins. A descriptor whose base plus offset wraps past 2^32 separates modular addition from a saturating or widened sum. Table entries carry junk in their upper bits, which shows that only the 20-bit field is used. Memory latency is varied from one to three cycles, and a request is injected mid-walk, which shows that reads wait for the valid strobe and that a busy block drops new requests.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LIM   = 3'd1,
    PH_BASE  = 3'd2,
    PH_OUTER = 3'd3,
    PH_INNER = 3'd4
  } phase_e;
endpackage

// File: rtl/segpage_rstsync.sv
module segpage_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/segpage_addr.sv
module segpage_addr
  import segpage_pkg::*;
#(
  parameter int SEG_W  = 13,
  parameter int AW     = 32,
  parameter int IDX_W  = 10,
  parameter int POFS_W = 12,
  parameter int FRM_W  = 20
) (
  input  phase_e             phase,
  input  logic [SEG_W-1:0]   seg,
  input  logic [AW-1:0]      tbl_base,
  input  logic [AW-1:0]      dir_base,
  input  logic [AW-1:0]      lin,
  input  logic [FRM_W-1:0]   inner_tbl,
  output logic [AW-1:0]      addr
);
  localparam int P2_LO = POFS_W;
  localparam int P1_LO = POFS_W + IDX_W;

  logic [AW-1:0]    desc_ofs;
  logic [IDX_W-1:0] p1;
  logic [IDX_W-1:0] p2;

  assign desc_ofs = AW'({seg, 1'b0});
  assign p1       = lin[P1_LO +: IDX_W];
  assign p2       = lin[P2_LO +: IDX_W];

  always_comb begin
    unique case (phase)
      PH_LIM:   addr = tbl_base + desc_ofs;
      PH_BASE:  addr = tbl_base + desc_ofs + AW'(1);
      PH_OUTER: addr = dir_base + AW'(p1);
      PH_INNER: addr = AW'({inner_tbl, p2});
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/segpage_walk.sv
module segpage_walk
  import segpage_pkg::*;
#(
  parameter int SEG_W  = 13,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int IDX_W  = 10,
  parameter int POFS_W = 12,
  parameter int FRM_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [AW-1:0]     off_i,
  input  logic [AW-1:0]     tbl_base_i,
  input  logic [SEG_W-1:0]  tbl_len_i,
  input  logic [AW-1:0]     dir_base_i,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output phase_e            phase_o,
  output logic [SEG_W-1:0]  seg_o,
  output logic [AW-1:0]     tbl_base_o,
  output logic [AW-1:0]     dir_base_o,
  output logic [AW-1:0]     lin_o,
  output logic [FRM_W-1:0]  inner_tbl_o,
  output logic              mem_rd_o,
  output logic              done_o,
  output logic              trap_o,
  output logic              fault_o,
  output logic [AW-1:0]     phys_o
);
  phase_e             phase_q, phase_d;
  logic               wait_q, wait_d;
  logic [SEG_W-1:0]   seg_q;
  logic [AW-1:0]      off_q, tbase_q, dbase_q, lin_q;
  logic [FRM_W-1:0]   tbl_q;
  logic               done_q, done_d, trap_q, trap_d, fault_q, fault_d;
  logic [AW-1:0]      phys_q, phys_d;
  logic               accept, hit, lin_en, tbl_en;

  assign accept = req_i && (phase_q == PH_IDLE);
  assign hit    = wait_q && mem_rvalid_i;

  always_comb begin
    phase_d = phase_q;
    wait_d  = wait_q ? !mem_rvalid_i : (phase_q != PH_IDLE);
    done_d  = 1'b0;
    trap_d  = 1'b0;
    fault_d = 1'b0;
    phys_d  = phys_q;
    lin_en  = 1'b0;
    tbl_en  = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          if (seg_i > tbl_len_i) begin
            done_d = 1'b1;
            trap_d = 1'b1;
            phys_d = '0;
          end else begin
            phase_d = PH_LIM;
          end
        end
      end
      PH_LIM: begin
        if (hit) begin
          if (off_q > AW'(mem_rdata_i)) begin
            done_d  = 1'b1;
            fault_d = 1'b1;
            phys_d  = '0;
            phase_d = PH_IDLE;
          end else begin
            phase_d = PH_BASE;
          end
        end
      end
      PH_BASE: begin
        if (hit) begin
          lin_en  = 1'b1;
          phase_d = PH_OUTER;
        end
      end
      PH_OUTER: begin
        if (hit) begin
          tbl_en  = 1'b1;
          phase_d = PH_INNER;
        end
      end
      PH_INNER: begin
        if (hit) begin
          done_d  = 1'b1;
          phys_d  = AW'({mem_rdata_i[FRM_W-1:0], lin_q[POFS_W-1:0]});
          phase_d = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      wait_q  <= 1'b0;
      seg_q   <= '0;
      off_q   <= '0;
      tbase_q <= '0;
      dbase_q <= '0;
      lin_q   <= '0;
      tbl_q   <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      fault_q <= 1'b0;
      phys_q  <= '0;
    end else begin
      phase_q <= phase_d;
      wait_q  <= wait_d;
      done_q  <= done_d;
      trap_q  <= trap_d;
      fault_q <= fault_d;
      if (accept) begin
        seg_q   <= seg_i;
        off_q   <= off_i;
        tbase_q <= tbl_base_i;
        dbase_q <= dir_base_i;
      end
      if (lin_en) lin_q  <= AW'(mem_rdata_i) + off_q;
      if (tbl_en) tbl_q  <= mem_rdata_i[FRM_W-1:0];
      if (done_d) phys_q <= phys_d;
    end
  end

  assign phase_o     = phase_q;
  assign seg_o       = seg_q;
  assign tbl_base_o  = tbase_q;
  assign dir_base_o  = dbase_q;
  assign lin_o       = lin_q;
  assign inner_tbl_o = tbl_q;
  assign mem_rd_o    = (phase_q != PH_IDLE) && !wait_q;
  assign done_o      = done_q;
  assign trap_o      = trap_q;
  assign fault_o     = fault_q;
  assign phys_o      = phys_q;

  AST_TRAP_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(trap_q && fault_q)); // R8
  AST_FLAG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q || fault_q) |-> done_q); // R8
  AST_ERR_PHYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_q || fault_q) |-> (phys_q == '0)); // R8
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o); // R7
  AST_TRAP_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> !$past(mem_rd_o)); // R1
  AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !mem_rd_o); // R7
endmodule

// File: rtl/segpage_xlat.sv
module segpage_xlat
  import segpage_pkg::*;
#(
  parameter int SEG_W  = 13,
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int IDX_W  = 10,
  parameter int POFS_W = 12,
  parameter int FRM_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [AW-1:0]     off_i,
  input  logic [AW-1:0]     tbl_base_i,
  input  logic [SEG_W-1:0]  tbl_len_i,
  input  logic [AW-1:0]     dir_base_i,
  output logic              mem_rd_o,
  output logic [AW-1:0]     mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DW-1:0]     mem_rdata_i,
  output logic              done_o,
  output logic              trap_o,
  output logic              fault_o,
  output logic [AW-1:0]     phys_o
);
  logic              rst_sync_n;
  phase_e            phase;
  logic [SEG_W-1:0]  seg_q;
  logic [AW-1:0]     tbase_q, dbase_q, lin_q;
  logic [FRM_W-1:0]  tbl_q;

  segpage_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  segpage_walk #(
    .SEG_W(SEG_W), .AW(AW), .DW(DW), .IDX_W(IDX_W), .POFS_W(POFS_W), .FRM_W(FRM_W)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .req_i        (req_i),
    .seg_i        (seg_i),
    .off_i        (off_i),
    .tbl_base_i   (tbl_base_i),
    .tbl_len_i    (tbl_len_i),
    .dir_base_i   (dir_base_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .phase_o      (phase),
    .seg_o        (seg_q),
    .tbl_base_o   (tbase_q),
    .dir_base_o   (dbase_q),
    .lin_o        (lin_q),
    .inner_tbl_o  (tbl_q),
    .mem_rd_o     (mem_rd_o),
    .done_o       (done_o),
    .trap_o       (trap_o),
    .fault_o      (fault_o),
    .phys_o       (phys_o)
  );

  segpage_addr #(
    .SEG_W(SEG_W), .AW(AW), .IDX_W(IDX_W), .POFS_W(POFS_W), .FRM_W(FRM_W)
  ) u_addr (
    .phase     (phase),
    .seg       (seg_q),
    .tbl_base  (tbase_q),
    .dir_base  (dbase_q),
    .lin       (lin_q),
    .inner_tbl (tbl_q),
    .addr      (mem_addr_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> !(done_o || trap_o || fault_o || mem_rd_o)); // R10
endmodule

// File: tb/segpage_xlat_tb.sv
module segpage_xlat_tb;
  localparam logic [31:0] TB_BASE = 32'h0000_0100;
  localparam logic [31:0] DB_BASE = 32'h0000_0200;
  localparam logic [12:0] TLEN    = 13'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_i = 1'b0;
  logic [12:0] seg_i = '0;
  logic [31:0] off_i = '0;
  logic        mem_rd_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o, trap_o, fault_o;
  logic [31:0] phys_o;

  int total = 0;
  int bad = 0;
  int lat = 1;
  int cnt = 0;
  int done_seen = 0;
  int exp_n = 0;
  int cyc = 0;
  bit live = 1'b0;
  bit finished = 1'b0;
  logic [31:0] paddr = '0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] q_addr[$];
  int          q_kind[$];
  logic [31:0] q_phys[$];

  always #4 clk = ~clk;

  segpage_xlat u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .seg_i(seg_i), .off_i(off_i),
    .tbl_base_i(TB_BASE), .tbl_len_i(TLEN), .dir_base_i(DB_BASE),
    .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .trap_o(trap_o), .fault_o(fault_o), .phys_o(phys_o)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // memory responder: data returned lat cycles after the strobe
  always @(negedge clk) begin
    mem_rvalid_i = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = rd(paddr);
      end
    end
    if (mem_rd_o) begin
      paddr = mem_addr_o;
      cnt   = lat;
    end
  end

  // per-clock comparison against the reference queues
  always @(negedge clk) begin
    if (live) begin
      cyc++;
      if (mem_rd_o) begin
        if (q_addr.size() == 0) chk(1'b0, "R7/R9 unexpected read", mem_addr_o, 32'h0);
        else begin
          chk(mem_addr_o == q_addr[0], "R4/R5/R7 read address", mem_addr_o, q_addr[0]);
          void'(q_addr.pop_front());
        end
      end
      if (done_o) begin
        done_seen++;
        if (q_kind.size() == 0) chk(1'b0, "R8/R9 unexpected done", 32'h1, 32'h0);
        else begin
          chk(trap_o == (q_kind[0] == 1), "R1/R2 trap flag", 32'(trap_o), 32'(q_kind[0] == 1));
          chk(fault_o == (q_kind[0] == 2), "R3 fault flag", 32'(fault_o), 32'(q_kind[0] == 2));
          chk(phys_o == q_phys[0], "R6/R8 physical address", phys_o, q_phys[0]);
          if (q_kind[0] != 0)
            chk(q_addr.size() == 0, "R1/R3 reads left over", 32'(q_addr.size()), 32'h0);
          void'(q_kind.pop_front());
          void'(q_phys.pop_front());
        end
      end else begin
        chk(!trap_o && !fault_o, "R8 flag without done", {30'h0, trap_o, fault_o}, 32'h0);
      end
    end
  end

  // place a mapping for a linear page with junk in the unused entry bits
  task automatic map_page(input logic [31:0] lin, input logic [19:0] frame);
    logic [19:0] tno;
    tno = 20'h00100 + 20'(lin[31:22]);
    mem[DB_BASE + 32'(lin[31:22])] = 32'hFFF0_0000 | 32'(tno);
    mem[32'({tno, lin[21:12]})]    = 32'hABC0_0000 | 32'(frame);
  endtask

  task automatic set_desc(input logic [12:0] s, input logic [31:0] lim, input logic [31:0] base);
    mem[TB_BASE + 32'(s) * 2]        = lim;
    mem[TB_BASE + 32'(s) * 2 + 32'd1] = base;
  endtask

  task automatic run(input logic [12:0] s, input logic [31:0] o, input int l, input bit poke);
    logic [31:0] la, lin, oe, ie;
    lat = l;
    if (s > TLEN) begin
      q_kind.push_back(1); q_phys.push_back(32'h0);
    end else begin
      la = TB_BASE + 32'(s) * 2;
      q_addr.push_back(la);
      if (o > rd(la)) begin
        q_kind.push_back(2); q_phys.push_back(32'h0);
      end else begin
        q_addr.push_back(la + 32'd1);
        lin = rd(la + 32'd1) + o;
        q_addr.push_back(DB_BASE + 32'(lin[31:22]));
        oe = rd(DB_BASE + 32'(lin[31:22]));
        ie = 32'({oe[19:0], lin[21:12]});
        q_addr.push_back(ie);
        q_kind.push_back(0);
        q_phys.push_back({rd(ie) & 32'h000F_FFFF} << 12 | 32'(lin[11:0]));
      end
    end
    exp_n++;
    @(negedge clk); req_i = 1'b1; seg_i = s; off_i = o;
    @(negedge clk); req_i = 1'b0;
    if (poke) begin
      // R9: a trapping request offered mid-walk must be dropped
      repeat (3) @(negedge clk);
      req_i = 1'b1; seg_i = 13'h1FFF; off_i = 32'h0;
      @(negedge clk); req_i = 1'b0;
    end
    while (done_seen < exp_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    set_desc(13'd0, 32'h0000_FFFF, 32'h0040_0000);
    set_desc(13'd2, 32'h0000_0010, 32'h0080_0000);
    set_desc(13'd3, 32'h0000_1000, 32'h00C0_3000);
    set_desc(13'd5, 32'hFFFF_FFFF, 32'hFFFF_F000);
    map_page(32'h0040_1234, 20'h12345);
    map_page(32'h0040_FFFF, 20'h0BEEF);
    map_page(32'h0000_0800, 20'hFACED);
    map_page(32'h00C0_3FFF, 20'h00777);

    repeat (3) @(negedge clk);
    // R10: outputs quiet while reset is held
    chk(!done_o && !trap_o && !fault_o && !mem_rd_o, "R10 reset state",
        {28'h0, done_o, trap_o, fault_o, mem_rd_o}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    run(13'd0, 32'h0000_1234, 1, 1'b0);   // R4 R5 R6 plain walk
    run(13'd0, 32'h0000_FFFF, 2, 1'b0);   // R3 offset equal to limit
    run(13'd0, 32'h0001_0000, 1, 1'b0);   // R3 offset one above limit
    run(13'd6, 32'h0000_0000, 1, 1'b0);   // R1 selector above length
    run(13'd5, 32'h0000_1800, 1, 1'b0);   // R2 equal to length, R5 wrap
    run(13'h1FFF, 32'hFFFF_FFFF, 1, 1'b0); // R1 trap wins over fault
    run(13'd3, 32'h0000_0FFF, 3, 1'b1);   // R7 slow memory, R9 mid-walk request
    run(13'd2, 32'h0000_0011, 2, 1'b0);   // R3 fault with slow memory

    repeat (10) @(negedge clk);
    chk(done_seen == exp_n, "R9 completion count", 32'(done_seen), 32'(exp_n));
    chk(q_addr.size() == 0, "R7 reads outstanding", 32'(q_addr.size()), 32'h0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=%0d exp=%0d", done_seen, exp_n);
    finish_run();
  end
endmodule